// File: doc/BRIEF.md
# Output Compare and Input Capture Timer

This block is a timer built around a free-running counter. Five channels compare their own compare register against the count. Three channels take a snapshot of the count when their input pin rises. One channel is shared: a configuration bit sets it to work either as the fifth compare channel or as the fourth capture channel. Four of the compare channels drive an output pin on a match. A two-bit action code chooses what happens to the pin: it can hold, toggle, go low or go high.

Every event sets a sticky flag. A mask register with the same bit layout gates the flags onto a single interrupt request. Software reads and writes all state through a small synchronous register port. A flag is cleared by writing a one to its bit.

Top module: `tmr_oc_unit`

## Requirements
- R1: The count register (address 0) resets to 0 and increases by one on every clock. After 16'hFFFF it wraps to 16'h0000.
- R2: A compare match happens on a clock edge where the count equals a channel's compare register. That edge sets the channel's flag. Compare registers sit at addresses 5 to 9 for channels 1 to 5. The flags are at address 3, bit 7 for channel 1 down to bit 4 for channel 4.
- R3: Pins oc_pin[0..3] belong to channels 2..5, and each pin changes on the same edge as its channel's match. Their action codes sit in the action register (address 1): channel 2 in bits [7:6], channel 3 in [5:4], channel 4 in [3:2] and channel 5 in [1:0]. The codes mean: 2'b00 hold the last value, 2'b01 toggle, 2'b10 drive 0, 2'b11 drive 1.
- R4: The shared-role bit is bit 0 of the config register (address 4). While it is 1, channel 5 has no compare function: a count match neither sets flag bit 3 nor moves oc_pin[3].
- R5: ic_pin[0..2] feed capture channels 1..3. Each pin passes through two synchronising flip-flops. A rising edge then loads the count into the channel's capture register (addresses 10, 11, 12) and sets flag bit 2, 1 or 0. The loaded value is the count read in the same cycle the pin was raised, plus 2.
- R6: While the shared-role bit is 1, a rising edge on ic_pin[3] loads the count into the shared register (address 9) and sets flag bit 3. The timing is the same as in R5. While the bit is 0, ic_pin[3] has no effect.
- R7: Writing the flag register clears each flag whose write-data bit is 1 and leaves flags whose bit is 0 unchanged. If an event sets a flag on the same edge, the set wins.
- R8: irq is high while any flag bit and the mask bit in the same position (address 2) are both 1. Mask bit 3 enables the shared channel in whichever role it is in.
- R9: Synchronous active-low reset clears the action, mask, flag and config registers, the compare and capture registers and all output pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| ic_pin | input | 4 | Capture inputs; bit 3 is the shared channel |
| oc_pin | output | 4 | Compare outputs for channels 2..5 |
| irq | output | 1 | Interrupt request |

## Verification
Random rounds choose a channel, an action code, the other channels' codes and a compare distance. They show whether the matched pin alone follows its code and whether pins that did not match stay put. Capture pulses arrive at random counts, which pins down the latency of the synchroniser.

The shared channel is run with the role bit both set and clear. This shows that the compare role, the capture role and the mask bit each switch with the bit. Directed cases cover a flag clear that lands on the same edge as a match, mask bits one position away from a set flag, and the counter wrap.

// File: rtl/tmr_pkg.sv
// Shared types and constants for the output compare / input capture timer.
// Assumes an 8-bit flag/mask layout and a 4-bit register address.
package tmr_pkg;
    typedef enum logic [1:0] {
        ACT_OFF  = 2'b00,
        ACT_TOG  = 2'b01,
        ACT_LOW  = 2'b10,
        ACT_HIGH = 2'b11
    } oc_act_e;

    localparam int FLAG_W = 8;
    localparam int N_CMP  = 5;
    localparam int N_CAP  = 3;
    localparam int N_PIN  = 4;

    localparam logic [3:0] A_CNT  = 4'd0;
    localparam logic [3:0] A_ACT  = 4'd1;
    localparam logic [3:0] A_MASK = 4'd2;
    localparam logic [3:0] A_FLAG = 4'd3;
    localparam logic [3:0] A_CFG  = 4'd4;
    localparam logic [3:0] A_CMP1 = 4'd5;
    localparam logic [3:0] A_CAP1 = 4'd10;
endpackage

// File: rtl/tmr_counter.sv
// Free-running up counter of parameter width.
// Assumes no prescaler: it advances on every clock and wraps naturally.
module tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] cnt
);
    // Advance the count every cycle; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/tmr_oc_pin.sv
// One compare channel with a driven pin: detects count == compare when
// enabled and applies the two-bit action to its pin on that edge.
// Assumes the action code is stable in the cycle of the match.
module tmr_oc_pin
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    input  logic         en,
    input  oc_act_e      act,
    output logic         hit,
    output logic         pin
);
    // Match is qualified by the channel enable.
    assign hit = en && (cnt == cmp);

    // Apply the action code to the pin on a match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin <= 1'b0;
        end else if (hit) begin
            unique case (act)
                ACT_OFF:  pin <= pin;
                ACT_TOG:  pin <= ~pin;
                ACT_LOW:  pin <= 1'b0;
                ACT_HIGH: pin <= 1'b1;
            endcase
        end
    end

    assert_pin_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit || act == ACT_OFF) |=> $stable(pin));
    assert_pin_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && act == ACT_TOG) |=> pin != $past(pin));
    assert_pin_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && act == ACT_HIGH) |=> pin);
endmodule

// File: rtl/tmr_ic_edge.sv
// Capture input front end: two-flop synchroniser then rising-edge detect.
// Assumes the pin is asynchronous; rise is a one-cycle pulse.
module tmr_ic_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic rise
);
    logic [2:0] sh_q;

    // Shift the pin through the sync pair and the edge history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[1:0], pin_in};
    end

    assign rise = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/tmr_oc_unit.sv
// Timer top: counter, five compare channels (four with pins, the fifth
// shared with capture 4), three capture channels, flags, mask and irq.
// Assumes single-cycle register writes and a combinational read port.
module tmr_oc_unit
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [3:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic [3:0]       ic_pin,
    output logic [3:0]       oc_pin,
    output logic             irq
);
    localparam int SH = N_CMP - 1;

    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cmp_q [N_CMP];
    logic [CNT_W-1:0]  cap_q [N_CAP];
    logic [7:0]        act_q;
    logic [FLAG_W-1:0] mask_q, flag_q, flag_set, flag_clr;
    logic              sel_q;
    logic              hit1;
    logic [N_PIN-1:0]  pin_hit;
    logic [3:0]        rise;

    tmr_counter #(.W(CNT_W)) u_cnt (.clk(clk), .rst_n(rst_n), .cnt(cnt));

    // Channel 1 compares only; it has no pin.
    assign hit1 = (cnt == cmp_q[0]);

    for (genvar i = 0; i < N_PIN; i++) begin : g_oc
        tmr_oc_pin #(.W(CNT_W)) u_oc (
            .clk(clk), .rst_n(rst_n), .cnt(cnt), .cmp(cmp_q[i+1]),
            .en((i == N_PIN - 1) ? !sel_q : 1'b1),
            .act(oc_act_e'(act_q[7-2*i -: 2])),
            .hit(pin_hit[i]), .pin(oc_pin[i]));
    end

    for (genvar i = 0; i < 4; i++) begin : g_ic
        tmr_ic_edge u_ic (.clk(clk), .rst_n(rst_n), .pin_in(ic_pin[i]), .rise(rise[i]));
    end

    // Event vector in flag-bit order.
    assign flag_set = {hit1, pin_hit[0], pin_hit[1], pin_hit[2],
                       sel_q ? rise[3] : pin_hit[3],
                       rise[0], rise[1], rise[2]};
    assign flag_clr = (bus_we && bus_addr == A_FLAG) ? bus_wdata[FLAG_W-1:0] : '0;

    // Control, mask and flag registers; a set beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= '0;
            mask_q <= '0;
            sel_q  <= 1'b0;
            flag_q <= '0;
        end else begin
            if (bus_we && bus_addr == A_ACT)  act_q  <= bus_wdata[7:0];
            if (bus_we && bus_addr == A_MASK) mask_q <= bus_wdata[FLAG_W-1:0];
            if (bus_we && bus_addr == A_CFG)  sel_q  <= bus_wdata[0];
            flag_q <= (flag_q & ~flag_clr) | flag_set;
        end
    end

    // Compare registers; the shared one also takes capture 4.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N_CMP; k++) cmp_q[k] <= '0;
        end else begin
            for (int k = 0; k < N_CMP; k++)
                if (bus_we && bus_addr == A_CMP1 + 4'(k)) cmp_q[k] <= bus_wdata;
            if (sel_q && rise[3]) cmp_q[SH] <= cnt;
        end
    end

    // Dedicated capture registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N_CAP; k++) cap_q[k] <= '0;
        end else begin
            for (int k = 0; k < N_CAP; k++)
                if (rise[k]) cap_q[k] <= cnt;
        end
    end

    // Read mux.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CNT:       bus_rdata = cnt;
            A_ACT:       bus_rdata[7:0] = act_q;
            A_MASK:      bus_rdata[FLAG_W-1:0] = mask_q;
            A_FLAG:      bus_rdata[FLAG_W-1:0] = flag_q;
            A_CFG:       bus_rdata[0] = sel_q;
            A_CMP1:      bus_rdata = cmp_q[0];
            A_CMP1 + 1:  bus_rdata = cmp_q[1];
            A_CMP1 + 2:  bus_rdata = cmp_q[2];
            A_CMP1 + 3:  bus_rdata = cmp_q[3];
            A_CMP1 + 4:  bus_rdata = cmp_q[4];
            A_CAP1:      bus_rdata = cap_q[0];
            A_CAP1 + 1:  bus_rdata = cap_q[1];
            A_CAP1 + 2:  bus_rdata = cap_q[2];
            default:     bus_rdata = '0;
        endcase
    end

    // Request while any enabled flag is pending.
    assign irq = |(flag_q & mask_q);

    assert_oc1_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit1 |=> flag_q[7]);
    assert_shared_no_cmp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q && cnt == cmp_q[SH] && !rise[3] && !flag_q[3]) |=> !flag_q[3]);
    assert_cap1_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rise[0] |=> cap_q[0] == $past(cnt));
    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_FLAG && bus_wdata[7] && !hit1) |=> !flag_q[7]);
endmodule

// File: tb/tmr_oc_unit_tb.sv
module tmr_oc_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] R_CNT = 0, R_ACT = 1, R_MASK = 2, R_FLAG = 3,
                           R_CFG = 4, R_CMP1 = 5, R_SH = 9, R_CAP1 = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  ic_pin = '0;
    logic [3:0]  oc_pin;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [3:0] exp_pin = '0;

    tmr_oc_unit u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ic_pin(ic_pin),
        .oc_pin(oc_pin), .irq(irq));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic next_pin(input logic [1:0] code, input logic cur);
        case (code)
            2'b00:   return cur;
            2'b01:   return ~cur;
            2'b10:   return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wait_cnt(input logic [15:0] t);
        logic [15:0] v;
        rd(R_CNT, v);
        while (v != t) begin
            @(negedge clk);
            rd(R_CNT, v);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 16'd1, 16'd0);
        finish_run();
    end

    initial begin
        logic [15:0] v, c, c2, shv;
        logic [1:0]  code;
        logic [7:0]  actv;
        int ch, d, bitn;
        v = 16'($urandom(32'd1234));

        // R9: reset state
        repeat (3) @(negedge clk);
        rd(R_ACT, v);  chk("R9 act", v, 16'h0);
        rd(R_MASK, v); chk("R9 mask", v, 16'h0);
        rd(R_FLAG, v); chk("R9 flag", v, 16'h0);
        rd(R_CFG, v);  chk("R9 cfg", v, 16'h0);
        rd(R_CMP1, v); chk("R9 cmp1", v, 16'h0);
        rd(R_CAP1, v); chk("R9 cap1", v, 16'h0);
        chk("R9 pins", {12'h0, oc_pin}, 16'h0);
        chk("R9 irq", {15'h0, irq}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        wr(R_FLAG, 16'hFF);

        // R1: single-step increment
        rd(R_CNT, c);
        @(negedge clk);
        rd(R_CNT, v);
        chk("R1 step", v, c + 16'd1);

        // R2/R3: random action codes on random pin channels
        for (int it = 0; it < 30; it++) begin
            ch   = $urandom_range(0, 3);
            code = (it < 4) ? 2'(it) : 2'($urandom_range(0, 3));
            actv = 8'($urandom);
            actv[7-2*ch -: 2] = code;
            wr(R_ACT, {8'h0, actv});
            rd(R_CNT, c);
            d = $urandom_range(4, 30);
            wr(R_CMP1 + 4'(ch + 1), c + 16'(d));
            chk("R3 pins before match", {12'h0, oc_pin}, {12'h0, exp_pin});
            wait_cnt(c + 16'(d) + 16'd1);
            exp_pin[ch] = next_pin(code, exp_pin[ch]);
            bitn = 6 - ch;
            rd(R_FLAG, v);
            chk("R2 flag on match", {15'h0, v[bitn]}, 16'h1);
            chk("R3 pins after match", {12'h0, oc_pin}, {12'h0, exp_pin});
            wr(R_FLAG, 16'(1 << bitn));
        end

        // R4: shared channel in capture role ignores compare
        wr(R_ACT, 16'h0001);
        wr(R_CFG, 16'h0001);
        rd(R_CNT, c);
        wr(R_SH, c + 16'd6);
        wait_cnt(c + 16'd8);
        rd(R_FLAG, v);
        chk("R4 no oc5 flag", {15'h0, v[3]}, 16'h0);
        chk("R4 oc5 pin held", {15'h0, oc_pin[3]}, {15'h0, exp_pin[3]});

        // R6: shared capture when role bit is 1
        rd(R_CNT, c);
        ic_pin[3] = 1'b1;
        repeat (3) @(negedge clk);
        rd(R_SH, v);
        chk("R6 shared capture", v, c + 16'd2);
        rd(R_FLAG, v);
        chk("R6 shared flag", {15'h0, v[3]}, 16'h1);
        ic_pin[3] = 1'b0;
        repeat (3) @(negedge clk);

        // R8: mask gating with the shared bit
        wr(R_MASK, 16'h0004);
        chk("R8 wrong mask bit", {15'h0, irq}, 16'h0);
        wr(R_MASK, 16'h0008);
        chk("R8 shared capture irq", {15'h0, irq}, 16'h1);

        // R7: write zero keeps, write one clears
        wr(R_FLAG, 16'h0000);
        rd(R_FLAG, v);
        chk("R7 write zero keeps", v & 16'h0008, 16'h0008);
        wr(R_FLAG, 16'h0008);
        rd(R_FLAG, v);
        chk("R7 write one clears", v & 16'h0008, 16'h0000);
        chk("R8 irq drops", {15'h0, irq}, 16'h0);

        // R6: ic_pin[3] ignored in compare role
        wr(R_CFG, 16'h0000);
        rd(R_SH, shv);
        ic_pin[3] = 1'b1;
        repeat (4) @(negedge clk);
        rd(R_SH, v);
        chk("R6 ignored in compare role", v, shv);
        rd(R_FLAG, v);
        chk("R6 no flag in compare role", {15'h0, v[3]}, 16'h0);
        ic_pin[3] = 1'b0;
        repeat (3) @(negedge clk);

        // R5: random capture pulses on dedicated channels
        for (int it = 0; it < 9; it++) begin
            ch = it % 3;
            repeat ($urandom_range(0, 7)) @(negedge clk);
            rd(R_CNT, c);
            ic_pin[ch] = 1'b1;
            repeat (3) @(negedge clk);
            rd(R_CAP1 + 4'(ch), v);
            chk("R5 capture value", v, c + 16'd2);
            rd(R_FLAG, v);
            chk("R5 capture flag", {15'h0, v[2-ch]}, 16'h1);
            ic_pin[ch] = 1'b0;
            repeat (3) @(negedge clk);
            wr(R_FLAG, 16'(1 << (2 - ch)));
        end

        // R7: clear on the same edge as a match leaves flag set
        wr(R_FLAG, 16'hFF);
        rd(R_CNT, c);
        wr(R_CMP1, c + 16'd6);
        wait_cnt(c + 16'd6);
        wr(R_FLAG, 16'h0080);
        rd(R_FLAG, v);
        chk("R7 set beats clear", {15'h0, v[7]}, 16'h1);

        // R8: mask must line up bit for bit
        wr(R_MASK, 16'h0040);
        chk("R8 neighbour mask bit", {15'h0, irq}, 16'h0);
        wr(R_MASK, 16'h0080);
        chk("R8 matching mask bit", {15'h0, irq}, 16'h1);

        // R1: wraparound
        wait_cnt(16'hFFFF);
        @(negedge clk);
        rd(R_CNT, c2);
        chk("R1 wrap", c2, 16'h0000);

        finish_run();
    end
endmodule